// File: doc/BRIEF.md
# Serial Memory Slave with Range Write Protection

This block is a serial-peripheral-bus slave that fronts a 4096-byte, byte-addressed memory held in an internal array. A host selects the block, shifts in a one-byte command followed by any address or data bytes, and shifts out read data or status on the same transfer. All bus pins are brought into the system clock domain through synchronisers. Data is taken on the rising bus-clock edge and launched on the falling edge, so a host may idle the bus clock either low or high (modes 0 and 3).

Writes do not reach the array directly. Data bytes fill a one-page staging buffer, with the in-page offset wrapping, and nothing happens until the host deselects on a byte boundary. At that point, if the write is enabled and the target page is not protected, a self-timed commit copies the staged bytes into the array and the block reports busy for a parameterised number of clock cycles. A two-bit protect field locks the top quarter, the top half or the whole array. That field can only be rewritten while the write-protect pin is high.

Top module: `spimem_slave`

## Requirements
- R1: The bus is accepted in mode 0 and mode 3: the input bit is taken on each rising bus-clock edge and the output bit changes on the falling edge. Bytes travel most significant bit first, and the output is low while deselected.
- R2: The status byte carries busy in bit 0, the write-enable flag in bit 1 and the protect field in bits 3:2, with bits 7:4 zero. After reset it reads 0x00. Command 0x05 returns it repeatedly for as long as the host keeps clocking.
- R3: Command 0x06 sets the write-enable flag and command 0x04 clears it.
- R4: Command 0x03 takes a two-byte address, of which the low 12 bits are used, and then returns consecutive bytes, incrementing the address after each one and wrapping from 0xFFF to 0x000.
- R5: Command 0x02 takes a two-byte address followed by data bytes. Each data byte lands at the next offset within the 32-byte page and wraps to the page start instead of crossing into the next page.
- R6: A write is committed only when deselect comes on a byte boundary after at least one data byte. The commit makes busy read 1 right away, lasts PAGE_BYTES plus WRITE_CLKS clock cycles, and ends with the write-enable flag cleared. A deselect in mid-byte discards the write.
- R7: With the write-enable flag clear, a memory write or status write is discarded and leaves the array and status unchanged.
- R8: Protect field 0 protects nothing, 1 protects addresses 0xC00 to 0xFFF, 2 protects 0x800 to 0xFFF, and 3 protects the whole array.
- R9: A write aimed at a protected page is discarded: busy never rises, the array keeps its old contents and the write-enable flag stays set.
- R10: Command 0x01 followed by one byte copies bits 3:2 of that byte into the protect field and clears the write-enable flag. While the write-protect pin is low the command is ignored.
- R11: While busy, every command other than status read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Bus clock from the host |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, registered |
| wp_n | input | 1 | Active low; when low, protect-field writes are blocked |

## Verification
The hardest state to reach from the pins is a command arriving while a commit is still running. The bench lengthens nothing in the design. It starts a page write and deselects, then at once issues a status read followed by a second full write command, and both fall inside the busy window that WRITE_CLKS sets. Afterwards, reading both target addresses shows that only the first write took effect. Deselecting in mid-byte is reached with a transfer task that can append stray bits after the last whole byte.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_WRIT = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADR, PH_RD, PH_WR, PH_STS, PH_WSR, PH_IGN
  } phase_t;

  // top2 = two most significant address bits of the target page
  function automatic logic prot_hit(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'd0:    prot_hit = 1'b0;
      2'd1:    prot_hit = (top2 == 2'b11);
      2'd2:    prot_hit = top2[1];
      default: prot_hit = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spimem_sync.sv
module spimem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_end,
  output logic mosi_s
);
  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] sck_p, csn_p, din_p;
  logic sck_d, csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p <= '0;
      csn_p <= '1;
      din_p <= '0;
      sck_d <= 1'b0;
      csn_d <= 1'b1;
    end else begin
      sck_p <= {sck_p[MSB-1:0], sclk};
      csn_p <= {csn_p[MSB-1:0], cs_n};
      din_p <= {din_p[MSB-1:0], mosi};
      sck_d <= sck_p[MSB];
      csn_d <= csn_p[MSB];
    end
  end

  assign sclk_rise = sck_p[MSB] & ~sck_d;
  assign sclk_fall = ~sck_p[MSB] & sck_d;
  assign cs_act    = ~csn_p[MSB];
  assign cs_end    = csn_p[MSB] & ~csn_d;
  assign mosi_s    = din_p[MSB];

endmodule

// File: rtl/spimem_ram.sv
module spimem_ram #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int WRITE_CLKS = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic wp_n
);
  localparam int PAGE_W   = $clog2(PAGE_BYTES);
  localparam int BUSY_LEN = PAGE_BYTES + WRITE_CLKS;
  localparam int BUSY_W   = $clog2(BUSY_LEN + 1);

  logic sclk_rise, sclk_fall, cs_act, cs_end, mosi_s;

  spimem_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
    .cs_end(cs_end), .mosi_s(mosi_s)
  );

  phase_t              phase;
  logic [2:0]          bit_cnt;
  logic [6:0]          rx_sh;
  logic [7:0]          rx_byte;
  logic                byte_done;
  logic [7:0]          op_q;
  logic                adr_idx;
  logic [7:0]          addr_hi;
  logic [ADDR_W-1:0]   addr_q;
  logic [PAGE_W-1:0]   woff;
  logic [7:0]          wbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] wvalid;
  logic                wany;
  logic [1:0]          wsr_bp;
  logic                wsr_got;
  logic                busy_q, wel_q;
  logic [1:0]          bp_q;
  logic [BUSY_W-1:0]   busy_cnt;
  logic [7:0]          tx_sh;
  logic [7:0]          status;
  logic [7:0]          tx_src;

  logic                ram_we;
  logic [ADDR_W-1:0]   ram_addr;
  logic [7:0]          ram_q;
  logic [PAGE_W-1:0]   slot;

  assign rx_byte   = {rx_sh, mosi_s};
  assign byte_done = cs_act && sclk_rise && (bit_cnt == 3'd7);
  assign status    = {4'b0, bp_q, wel_q, busy_q};
  assign slot      = busy_cnt[PAGE_W-1:0];
  assign ram_we    = busy_q && (busy_cnt < BUSY_W'(PAGE_BYTES)) && wvalid[slot];
  assign ram_addr  = busy_q ? {addr_q[ADDR_W-1:PAGE_W], slot} : addr_q;

  spimem_ram #(.AW(ADDR_W), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(wbuf[slot]), .rdata(ram_q)
  );

  // Page staging buffer: written from the bus, read during commit
  always_ff @(posedge clk) begin
    if (byte_done && phase == PH_WR) wbuf[woff] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_OPC;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      op_q     <= '0;
      adr_idx  <= 1'b0;
      addr_hi  <= '0;
      addr_q   <= '0;
      woff     <= '0;
      wvalid   <= '0;
      wany     <= 1'b0;
      wsr_bp   <= '0;
      wsr_got  <= 1'b0;
      busy_q   <= 1'b0;
      wel_q    <= 1'b0;
      bp_q     <= '0;
      busy_cnt <= '0;
    end else begin
      // self-timed commit
      if (busy_q) begin
        if (busy_cnt == BUSY_W'(BUSY_LEN - 1)) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
        end
        busy_cnt <= busy_cnt + 1'b1;
      end

      if (!cs_act) begin
        bit_cnt <= '0;
        phase   <= PH_OPC;
      end else if (sclk_rise) begin
        bit_cnt <= bit_cnt + 1'b1;
        rx_sh   <= rx_byte[6:0];
      end

      if (byte_done) begin
        case (phase)
          PH_OPC: begin
            wsr_got <= 1'b0;
            if (busy_q && rx_byte != OPC_RDSR) phase <= PH_IGN;
            else begin
              case (rx_byte)
                OPC_WREN: begin wel_q <= 1'b1; phase <= PH_IGN; end
                OPC_WRDI: begin wel_q <= 1'b0; phase <= PH_IGN; end
                OPC_RDSR: phase <= PH_STS;
                OPC_WRSR: phase <= PH_WSR;
                OPC_READ, OPC_WRIT: begin
                  phase   <= PH_ADR;
                  op_q    <= rx_byte;
                  adr_idx <= 1'b0;
                  wvalid  <= '0;
                  wany    <= 1'b0;
                end
                default: phase <= PH_IGN;
              endcase
            end
          end
          PH_ADR: begin
            if (!adr_idx) begin
              addr_hi <= rx_byte;
              adr_idx <= 1'b1;
            end else begin
              addr_q <= ADDR_W'({addr_hi, rx_byte});
              woff   <= rx_byte[PAGE_W-1:0];
              phase  <= (op_q == OPC_READ) ? PH_RD : PH_WR;
            end
          end
          PH_RD: addr_q <= addr_q + 1'b1;
          PH_WR: begin
            wvalid[woff] <= 1'b1;
            woff         <= woff + 1'b1;
            wany         <= 1'b1;
          end
          PH_WSR: begin
            wsr_bp  <= rx_byte[3:2];
            wsr_got <= 1'b1;
            phase   <= PH_IGN;
          end
          default: ;
        endcase
      end

      if (cs_end && bit_cnt == 3'd0) begin
        if (phase == PH_WR && wany && wel_q && !busy_q &&
            !prot_hit(bp_q, addr_q[ADDR_W-1 -: 2])) begin
          busy_q   <= 1'b1;
          busy_cnt <= '0;
        end
        if (wsr_got && wel_q && wp_n && !busy_q) begin
          bp_q  <= wsr_bp;
          wel_q <= 1'b0;
        end
      end
    end
  end

  // Output side: launch on falling edge
  always_comb begin
    case (phase)
      PH_STS:  tx_src = status;
      PH_RD:   tx_src = ram_q;
      default: tx_src = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_act) begin
      spi_miso <= 1'b0;
      tx_sh    <= '0;
    end else if (sclk_fall) begin
      if (bit_cnt == 3'd0) begin
        spi_miso <= tx_src[7];
        tx_sh    <= {tx_src[6:0], 1'b0};
      end else begin
        spi_miso <= tx_sh[7];
        tx_sh    <= {tx_sh[6:0], 1'b0};
      end
    end
  end

  // R6
  busy_needs_deselect_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(cs_end));
  // R7
  busy_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> wel_q);
  // R6
  wel_drops_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> !wel_q);
  // R9
  no_commit_protected_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> !prot_hit(bp_q, addr_q[ADDR_W-1 -: 2]));
  // R10
  bp_change_needs_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_q != $past(bp_q)) |-> $past(wp_n));
  // R1
  miso_quiet_deselected_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_act) |-> !spi_miso);

endmodule

// File: tb/spimem_slave_test.sv
module spimem_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] txb [40];
  logic [7:0] rxb [40];

  always #4 clk = ~clk;

  spimem_slave uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .wp_n(wp_n)
  );

  task automatic hw();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // nb whole bytes, then extra stray bits before deselect
  task automatic xact(input int nb, input bit m3, input int extra = 0);
    sclk = m3; hw(); hw();
    cs_n = 1'b0; hw();
    for (int b = 0; b < nb; b++) begin
      for (int i = 7; i >= 0; i--) begin
        if (m3) sclk = 1'b0;
        mosi = txb[b][i]; hw();
        rxb[b][i] = miso;
        sclk = 1'b1; hw();
        if (!m3) sclk = 1'b0;
      end
    end
    for (int i = 0; i < extra; i++) begin
      if (m3) sclk = 1'b0;
      mosi = 1'b1; hw();
      sclk = 1'b1; hw();
      if (!m3) sclk = 1'b0;
    end
    hw(); cs_n = 1'b1; hw(); hw();
  endtask

  task automatic cmd1(input logic [7:0] op, input bit m3 = 0);
    txb[0] = op; xact(1, m3);
  endtask

  task automatic rdsr(output logic [7:0] s, input bit m3 = 0);
    txb[0] = 8'h05; txb[1] = 8'h00; txb[2] = 8'h00; xact(3, m3);
    s = rxb[1];
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  // write nd bytes starting at value d0 incrementing by 1
  task automatic wr(input logic [11:0] a, input int nd, input logic [7:0] d0,
                    input bit m3 = 0, input int extra = 0);
    txb[0] = 8'h02; txb[1] = {4'h0, a[11:8]}; txb[2] = a[7:0];
    for (int i = 0; i < nd; i++) txb[3+i] = d0 + 8'(i);
    xact(3 + nd, m3, extra);
  endtask

  task automatic rd(input logic [11:0] a, input int nd, input bit m3 = 0);
    txb[0] = 8'h03; txb[1] = {4'h0, a[11:8]}; txb[2] = a[7:0];
    for (int i = 0; i < nd; i++) txb[3+i] = 8'h00;
    xact(3 + nd, m3);
  endtask

  task automatic commit(input logic [11:0] a, input int nd, input logic [7:0] d0);
    cmd1(8'h06); wr(a, nd, d0); wait_idle();
  endtask

  task automatic set_bp(input logic [1:0] bp);
    cmd1(8'h06);
    txb[0] = 8'h01; txb[1] = {4'h0, bp, 2'b00}; xact(2, 0);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    rdsr(s); check("R2 reset status", s, 8'h00);
    check("R1 miso idle low", miso, 1'b0);
  endtask

  task automatic t_wel();
    logic [7:0] s;
    cmd1(8'h06); rdsr(s); check("R3 set wel", s, 8'h02);
    txb[0] = 8'h05; for (int i = 1; i < 5; i++) txb[i] = 8'h00;
    xact(5, 0); check("R2 repeated status", rxb[4], 8'h02);
    cmd1(8'h04, 1); rdsr(s, 1); check("R3 clear wel", s, 8'h00);
  endtask

  task automatic t_write_read();
    logic [7:0] s;
    cmd1(8'h06); wr(12'h010, 3, 8'hAA);
    rdsr(s); check("R6 busy right after commit", s, 8'h03);
    wait_idle(); rdsr(s); check("R6 wel cleared after commit", s, 8'h00);
    rd(12'h010, 3);
    check("R4 read 0x010", rxb[3], 8'hAA);
    check("R4 read 0x011", rxb[4], 8'hAB);
    check("R4 read 0x012", rxb[5], 8'hAC);
  endtask

  task automatic t_page_wrap();
    commit(12'h040, 1, 8'h55);
    commit(12'h03E, 4, 8'h01);
    rd(12'h03E, 3);
    check("R5 0x03E", rxb[3], 8'h01);
    check("R5 0x03F", rxb[4], 8'h02);
    check("R5 next page untouched", rxb[5], 8'h55);
    rd(12'h020, 2);
    check("R5 wrapped 0x020", rxb[3], 8'h03);
    check("R5 wrapped 0x021", rxb[4], 8'h04);
  endtask

  task automatic t_read_wrap();
    cmd1(8'h06, 1); wr(12'hFFF, 1, 8'h77, 1); wait_idle();
    commit(12'h000, 1, 8'h66);
    rd(12'hFFF, 2, 1);
    check("R4 mode3 0xFFF", rxb[3], 8'h77);
    check("R4 wrap to 0x000", rxb[4], 8'h66);
  endtask

  task automatic t_no_wel();
    logic [7:0] s;
    cmd1(8'h04); wr(12'h010, 1, 8'hEE);
    rdsr(s); check("R7 no busy without wel", s, 8'h00);
    rd(12'h010, 1); check("R7 data unchanged", rxb[3], 8'hAA);
    txb[0] = 8'h01; txb[1] = 8'h0C; xact(2, 0);
    rdsr(s); check("R7 status write without wel", s, 8'h00);
  endtask

  task automatic t_partial();
    logic [7:0] s;
    cmd1(8'h06); wr(12'h010, 1, 8'h12, 0, 3);
    rdsr(s); check("R6 mid-byte deselect discards", s, 8'h02);
    rd(12'h010, 1); check("R6 data kept", rxb[3], 8'hAA);
    cmd1(8'h04);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    commit(12'h100, 1, 8'h11);
    cmd1(8'h06); wr(12'h200, 1, 8'h22);
    rdsr(s); check("R11 status read while busy", s, 8'h03);
    wr(12'h100, 1, 8'h99);
    wait_idle();
    rd(12'h100, 1); check("R11 write during busy ignored", rxb[3], 8'h11);
    rd(12'h200, 1); check("R6 first write landed", rxb[3], 8'h22);
  endtask

  task automatic t_protect();
    logic [7:0] s;
    commit(12'hC00, 1, 8'h5A);
    commit(12'h800, 1, 8'h4B);
    set_bp(2'd1); rdsr(s); check("R10 bp=1 set, wel cleared", s, 8'h04);
    cmd1(8'h06); wr(12'hC00, 1, 8'h00);
    rdsr(s); check("R9 protected: no busy, wel kept", s, 8'h06);
    rd(12'hC00, 1); check("R8 upper quarter locked", rxb[3], 8'h5A);
    wr(12'hBFF, 1, 8'h3C); wait_idle();
    rd(12'hBFF, 1); check("R8 below quarter writable", rxb[3], 8'h3C);
    set_bp(2'd2);
    cmd1(8'h06); wr(12'h800, 1, 8'h00);
    rd(12'h800, 1); check("R8 upper half locked", rxb[3], 8'h4B);
    wait_idle();
    cmd1(8'h04); set_bp(2'd3);
    cmd1(8'h06); wr(12'h000, 1, 8'h00);
    rd(12'h000, 1); check("R8 whole array locked", rxb[3], 8'h66);
    cmd1(8'h04); set_bp(2'd0);
    rdsr(s); check("R10 bp cleared", s, 8'h00);
  endtask

  task automatic t_wp();
    logic [7:0] s;
    set_bp(2'd1);
    wp_n = 1'b0;
    cmd1(8'h06, 1);
    txb[0] = 8'h01; txb[1] = 8'h0C; xact(2, 1);
    rdsr(s, 1); check("R10 wp low blocks status write", s, 8'h06);
    wp_n = 1'b1;
    txb[0] = 8'h01; txb[1] = 8'h00; xact(2, 1);
    rdsr(s, 1); check("R10 wp high allows status write", s, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_wel();
    t_write_read();
    t_page_wrap();
    t_read_wrap();
    t_no_wel();
    t_partial();
    t_busy();
    t_protect();
    t_wp();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule